// File: doc/BRIEF.md
# Layered Overcurrent Protection Engine

This block watches a stream of current-magnitude samples from an inverter's sense path, together with a strobe that marks every switching edge, and decides whether the power stage must be shut down. It weighs each sample through three tiers of increasing patience. The fast tier cuts the gate in the very switching cycle where an unblanked sample passes an absolute limit. The confirmed tier tracks the peak of every window of a few switching cycles and trips only after several over-threshold windows in a row. The integral tier builds up the excess current over a programmable period and trips when that sum passes a budget.

A short blanking interval follows each switching edge. Samples inside it never reach the fast or confirmed tiers, because ringing on the sense path right after an edge is not real current. A switching cycle whose only over-limit samples fell inside blanking is logged as a nuisance event in a saturating counter instead of tripping. Once any tier fires, a latched trip holds the gate off and records the tier that caused it, until an explicit clear arrives.

Top module: `ocp_tiered_guard`

## Requirements
- R1: A valid sample outside blanking whose magnitude is strictly above `lim_fast` sets `trip` and `gate_kill` and sets `trip_path` to 01, visible after the next rising clock edge. A sample with `smp_vld` low has no effect on any tier.
- R2: The clock cycle in which `edge_stb` is high and the following BLANK_LEN-1 cycles are blanked. Samples in these cycles never fire the fast tier, never enter the confirmed tier's window peak, and never touch the accumulator.
- R3: A window closes on every WIN_CYC-th edge strobe and compares its peak of unblanked samples, strictly, against `lim_win`. `soft_limit` shows the result of the most recently closed window. `trip_path` 10 is latched only when CONFIRM_N consecutive windows were over, and one window that is not over restarts the run.
- R4: Each unblanked valid sample above `lim_ovl` adds `smp_mag - lim_ovl` to the accumulator. When the new total is strictly above `acc_budget`, `trip_path` 11 is latched. A total equal to the budget does not trip.
- R5: Each unblanked valid sample at or below `lim_ovl` lowers the accumulator toward zero, never below it. With the default linear leak the step is `leak_step`.
- R6: The accumulator is cleared in the last cycle of every `per_len`-cycle period, and the sample in that cycle is dropped. Steady overload that stays under budget within every period never trips.
- R7: At each edge strobe, if the cycle that just ended had a blanked sample above `lim_fast` and no unblanked sample above it, `nuis_cnt` rises by one on the next clock. The counter saturates at all ones and changes at no other time.
- R8: Once set, `trip`, `gate_kill` and `trip_path` hold until `trip_clr`, and the first tier to fire is kept. When tiers fire in the same cycle the priority is 01, then 10, then 11. `trip_path` reads 00 whenever `trip` is low.
- R9: `trip_clr` drops `trip`, `gate_kill`, `soft_limit` and `trip_path`. It also restarts the confirmation run, the window peak, the window phase, the accumulator and the period counter. It leaves `nuis_cnt` unchanged.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_stb | input | 1 | One-cycle strobe at each switching edge |
| smp_vld | input | 1 | Current sample valid this cycle |
| smp_mag | input | MAG_W | Current magnitude sample |
| lim_fast | input | MAG_W | Absolute limit for the fast tier |
| lim_win | input | MAG_W | Window-peak threshold for the confirmed tier |
| lim_ovl | input | MAG_W | Overload level for the integral tier |
| acc_budget | input | ACC_W | Excess budget for the integral tier |
| leak_step | input | ACC_W | Leak amount (linear) or shift (proportional) |
| per_len | input | PER_W | Integration period in clock cycles |
| trip_clr | input | 1 | Clears the latched trip |
| gate_kill | output | 1 | Gate shutdown request |
| soft_limit | output | 1 | Last closed window was over threshold |
| trip | output | 1 | Latched trip flag |
| trip_path | output | 2 | Tier that caused the trip: 01, 10, 11 |
| nuis_cnt | output | NC_W | Saturating nuisance-event count |

## Verification
The bench builds the block with BLANK_LEN=3, WIN_CYC=2 and CONFIRM_N=3. Each five-clock switching cycle then has three blanked and two quiet samples, and a confirmed trip needs six cycles, so one table can walk window closing, a broken streak and the final trip. NC_W=4 brings counter saturation within a few dozen cycles instead of tens of thousands. Integration periods of 10 and 1000 clock cycles stand in for the millisecond periods, which is enough to exercise the period clear, the leak and the strict budget comparison.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

   typedef enum logic [1:0] {
      PATH_NONE = 2'b00,
      PATH_FAST = 2'b01,
      PATH_CONF = 2'b10,
      PATH_INTG = 2'b11
   } trip_path_e;

endpackage

// File: rtl/ocp_fast_tier.sv
module ocp_fast_tier #(
   parameter int MAG_W     = 12,
   parameter int BLANK_LEN = 4,
   parameter int NC_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_stb,
   input  logic             smp_vld,
   input  logic [MAG_W-1:0] smp_mag,
   input  logic [MAG_W-1:0] lim_fast,
   output logic             quiet_vld,
   output logic             fast_fire,
   output logic [NC_W-1:0]  nuis_cnt
);

   localparam int BLK_W = $clog2(BLANK_LEN + 1);
   localparam logic [BLK_W-1:0] BLK_LOAD = BLK_W'(BLANK_LEN - 1);
   localparam logic [NC_W-1:0]  NC_MAX   = '1;

   logic [BLK_W-1:0] blank_cnt;
   logic             blanked;
   logic             over_abs;
   logic             ring_now;
   logic             ring_seen;
   logic             hit_seen;

   // blanking covers the edge cycle and BLANK_LEN-1 cycles after it
   assign blanked   = edge_stb || (blank_cnt != '0);
   assign over_abs  = smp_mag > lim_fast;
   assign quiet_vld = smp_vld && !blanked;
   assign fast_fire = quiet_vld && over_abs;
   assign ring_now  = smp_vld && blanked && over_abs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blank_cnt <= '0;
      end else if (edge_stb) begin
         blank_cnt <= BLK_LOAD;
      end else if (blank_cnt != '0) begin
         blank_cnt <= blank_cnt - BLK_W'(1);
      end
   end

   // per-cycle classification of ringing-only peaks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_seen <= 1'b0;
         hit_seen  <= 1'b0;
         nuis_cnt  <= '0;
      end else if (edge_stb) begin
         if (ring_seen && !hit_seen && (nuis_cnt != NC_MAX)) begin
            nuis_cnt <= nuis_cnt + NC_W'(1);
         end
         ring_seen <= ring_now;
         hit_seen  <= 1'b0;
      end else begin
         ring_seen <= ring_seen | ring_now;
         hit_seen  <= hit_seen | fast_fire;
      end
   end

endmodule

// File: rtl/ocp_window_tier.sv
module ocp_window_tier #(
   parameter int MAG_W     = 12,
   parameter int WIN_CYC   = 4,
   parameter int CONFIRM_N = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             edge_stb,
   input  logic             quiet_vld,
   input  logic [MAG_W-1:0] smp_mag,
   input  logic [MAG_W-1:0] lim_win,
   output logic             soft_over,
   output logic             conf_fire
);

   localparam int WC_W = $clog2(WIN_CYC + 1);
   localparam int CN_W = $clog2(CONFIRM_N + 1);
   localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN_CYC - 1);
   localparam logic [CN_W-1:0] CN_TOP  = CN_W'(CONFIRM_N);

   logic [WC_W-1:0]  edge_cnt;
   logic [MAG_W-1:0] win_peak;
   logic [CN_W-1:0]  streak;
   logic [CN_W-1:0]  streak_nx;
   logic             win_close;
   logic             win_over;

   assign win_close = edge_stb && (edge_cnt == WC_LAST);
   assign win_over  = win_peak > lim_win;

   always_comb begin
      if (!win_over) begin
         streak_nx = '0;
      end else if (streak == CN_TOP) begin
         streak_nx = streak;
      end else begin
         streak_nx = streak + CN_W'(1);
      end
   end

   assign conf_fire = win_close && win_over && (streak_nx == CN_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt  <= '0;
         win_peak  <= '0;
         streak    <= '0;
         soft_over <= 1'b0;
      end else if (clr) begin
         edge_cnt  <= '0;
         win_peak  <= '0;
         streak    <= '0;
         soft_over <= 1'b0;
      end else begin
         if (edge_stb) begin
            edge_cnt <= win_close ? '0 : edge_cnt + WC_W'(1);
         end
         if (win_close) begin
            win_peak  <= '0;
            streak    <= streak_nx;
            soft_over <= win_over;
         end else if (quiet_vld && (smp_mag > win_peak)) begin
            win_peak <= smp_mag;
         end
      end
   end

endmodule

// File: rtl/ocp_integ_tier.sv
module ocp_integ_tier #(
   parameter int MAG_W      = 12,
   parameter int ACC_W      = 32,
   parameter int PER_W      = 24,
   parameter int LEAK_SHIFT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             quiet_vld,
   input  logic [MAG_W-1:0] smp_mag,
   input  logic [MAG_W-1:0] lim_ovl,
   input  logic [ACC_W-1:0] acc_budget,
   input  logic [ACC_W-1:0] leak_step,
   input  logic [PER_W-1:0] per_len,
   output logic             intg_fire
);

   localparam int PAD_W = ACC_W - MAG_W;

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] acc_nx;
   logic [ACC_W-1:0] acc_up;
   logic [ACC_W-1:0] acc_dn;
   logic [ACC_W-1:0] dec;
   logic [ACC_W-1:0] excess;
   logic [ACC_W:0]   sum;
   logic [PER_W-1:0] per_cnt;
   logic             per_end;
   logic             over_ovl;

   assign over_ovl = smp_mag > lim_ovl;
   assign excess   = {{PAD_W{1'b0}}, smp_mag - lim_ovl};
   assign sum      = {1'b0, acc} + {1'b0, excess};
   assign acc_up   = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
   assign per_end  = ({1'b0, per_cnt} + (PER_W+1)'(1)) >= {1'b0, per_len};

   // leak variant: fixed step or fraction of the current total
   generate
      if (LEAK_SHIFT == 0) begin : g_leak_lin
         assign dec = leak_step;
      end else begin : g_leak_prop
         assign dec = acc >> leak_step;
      end
   endgenerate

   assign acc_dn = (acc > dec) ? (acc - dec) : '0;

   always_comb begin
      acc_nx = acc;
      if (quiet_vld) begin
         acc_nx = over_ovl ? acc_up : acc_dn;
      end
   end

   assign intg_fire = quiet_vld && over_ovl && !per_end && (sum > {1'b0, acc_budget});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         per_cnt <= '0;
      end else if (clr || per_end) begin
         acc     <= '0;
         per_cnt <= '0;
      end else begin
         acc     <= acc_nx;
         per_cnt <= per_cnt + PER_W'(1);
      end
   end

endmodule

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch
   import ocp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       fast_fire,
   input  logic       conf_fire,
   input  logic       intg_fire,
   output logic       trip,
   output trip_path_e path_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trip   <= 1'b0;
         path_q <= PATH_NONE;
      end else if (clr) begin
         trip   <= 1'b0;
         path_q <= PATH_NONE;
      end else if (!trip) begin
         if (fast_fire) begin
            trip   <= 1'b1;
            path_q <= PATH_FAST;
         end else if (conf_fire) begin
            trip   <= 1'b1;
            path_q <= PATH_CONF;
         end else if (intg_fire) begin
            trip   <= 1'b1;
            path_q <= PATH_INTG;
         end
      end
   end

endmodule

// File: rtl/ocp_tiered_guard.sv
module ocp_tiered_guard
   import ocp_pkg::*;
#(
   parameter int MAG_W      = 12,
   parameter int BLANK_LEN  = 4,
   parameter int WIN_CYC    = 4,
   parameter int CONFIRM_N  = 3,
   parameter int ACC_W      = 32,
   parameter int PER_W      = 24,
   parameter int NC_W       = 16,
   parameter int LEAK_SHIFT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_stb,
   input  logic             smp_vld,
   input  logic [MAG_W-1:0] smp_mag,
   input  logic [MAG_W-1:0] lim_fast,
   input  logic [MAG_W-1:0] lim_win,
   input  logic [MAG_W-1:0] lim_ovl,
   input  logic [ACC_W-1:0] acc_budget,
   input  logic [ACC_W-1:0] leak_step,
   input  logic [PER_W-1:0] per_len,
   input  logic             trip_clr,
   output logic             gate_kill,
   output logic             soft_limit,
   output logic             trip,
   output logic [1:0]       trip_path,
   output logic [NC_W-1:0]  nuis_cnt
);

   generate
      if (MAG_W < 2) begin : g_bad_mag
         $error("MAG_W must be at least 2");
      end
      if (BLANK_LEN < 1) begin : g_bad_blank
         $error("BLANK_LEN must be at least 1");
      end
      if (WIN_CYC < 1) begin : g_bad_win
         $error("WIN_CYC must be at least 1");
      end
      if (CONFIRM_N < 1) begin : g_bad_conf
         $error("CONFIRM_N must be at least 1");
      end
      if (ACC_W <= MAG_W) begin : g_bad_acc
         $error("ACC_W must exceed MAG_W");
      end
      if (PER_W < 1 || NC_W < 1) begin : g_bad_cnt
         $error("PER_W and NC_W must be at least 1");
      end
      if (LEAK_SHIFT != 0 && LEAK_SHIFT != 1) begin : g_bad_leak
         $error("LEAK_SHIFT selects 0 (linear) or 1 (proportional)");
      end
   endgenerate

   logic       quiet_vld;
   logic       fast_fire;
   logic       conf_fire;
   logic       intg_fire;
   trip_path_e path_q;

   ocp_fast_tier #(
      .MAG_W     (MAG_W),
      .BLANK_LEN (BLANK_LEN),
      .NC_W      (NC_W)
   ) u_fast (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_stb  (edge_stb),
      .smp_vld   (smp_vld),
      .smp_mag   (smp_mag),
      .lim_fast  (lim_fast),
      .quiet_vld (quiet_vld),
      .fast_fire (fast_fire),
      .nuis_cnt  (nuis_cnt)
   );

   ocp_window_tier #(
      .MAG_W     (MAG_W),
      .WIN_CYC   (WIN_CYC),
      .CONFIRM_N (CONFIRM_N)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (trip_clr),
      .edge_stb  (edge_stb),
      .quiet_vld (quiet_vld),
      .smp_mag   (smp_mag),
      .lim_win   (lim_win),
      .soft_over (soft_limit),
      .conf_fire (conf_fire)
   );

   ocp_integ_tier #(
      .MAG_W      (MAG_W),
      .ACC_W      (ACC_W),
      .PER_W      (PER_W),
      .LEAK_SHIFT (LEAK_SHIFT)
   ) u_intg (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (trip_clr),
      .quiet_vld  (quiet_vld),
      .smp_mag    (smp_mag),
      .lim_ovl    (lim_ovl),
      .acc_budget (acc_budget),
      .leak_step  (leak_step),
      .per_len    (per_len),
      .intg_fire  (intg_fire)
   );

   ocp_trip_latch u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (trip_clr),
      .fast_fire (fast_fire),
      .conf_fire (conf_fire),
      .intg_fire (intg_fire),
      .trip      (trip),
      .path_q    (path_q)
   );

   assign trip_path = path_q;
   assign gate_kill = trip;

endmodule

// File: rtl/ocp_tiered_guard_chk.sv
module ocp_tiered_guard_chk #(
   parameter int NC_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            edge_stb,
   input logic            quiet_vld,
   input logic            fast_fire,
   input logic            trip_clr,
   input logic            trip,
   input logic            gate_kill,
   input logic            soft_limit,
   input logic [1:0]      trip_path,
   input logic [NC_W-1:0] nuis_cnt
);

   // R1: an unblanked over-limit sample trips through the fast path
   a_r1_fast_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_fire && !trip && !trip_clr) |=> (trip && gate_kill && trip_path == 2'b01));

   // R2: the edge cycle itself is always blanked
   a_r2_edge_blanked: assert property (@(posedge clk) disable iff (!rst_n)
      edge_stb |-> (!quiet_vld && !fast_fire));

   // R7: the counter moves only by one, only after an edge strobe
   a_r7_nuis_step: assert property (@(posedge clk) disable iff (!rst_n)
      (nuis_cnt != $past(nuis_cnt)) |-> ($past(edge_stb) && nuis_cnt == $past(nuis_cnt) + NC_W'(1)));

   // R8: a trip and its path hold until cleared
   a_r8_trip_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (trip && !trip_clr) |=> (trip && $stable(trip_path)));

   // R8: the path code is nonzero exactly while tripped
   a_r8_path_code: assert property (@(posedge clk) disable iff (!rst_n)
      (trip == (trip_path != 2'b00)));

   // R9: a clear drops the trip, the path and the soft request
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      trip_clr |=> (!trip && !gate_kill && !soft_limit && trip_path == 2'b00));

endmodule

bind ocp_tiered_guard ocp_tiered_guard_chk #(.NC_W(NC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .edge_stb   (edge_stb),
   .quiet_vld  (quiet_vld),
   .fast_fire  (fast_fire),
   .trip_clr   (trip_clr),
   .trip       (trip),
   .gate_kill  (gate_kill),
   .soft_limit (soft_limit),
   .trip_path  (trip_path),
   .nuis_cnt   (nuis_cnt)
);

// File: tb/sim_ocp_tiered_guard.sv
module sim_ocp_tiered_guard;

   localparam int MAG_W = 12;
   localparam int ACC_W = 24;
   localparam int PER_W = 16;
   localparam int NC_W  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             edge_stb = 1'b0;
   logic             smp_vld = 1'b0;
   logic [MAG_W-1:0] smp_mag = '0;
   logic [MAG_W-1:0] lim_fast = 12'd1000;
   logic [MAG_W-1:0] lim_win = 12'd600;
   logic [MAG_W-1:0] lim_ovl = 12'd4095;
   logic [ACC_W-1:0] acc_budget = '1;
   logic [ACC_W-1:0] leak_step = 24'd10;
   logic [PER_W-1:0] per_len = 16'd1000;
   logic             trip_clr = 1'b0;
   logic             gate_kill;
   logic             soft_limit;
   logic             trip;
   logic [1:0]       trip_path;
   logic [NC_W-1:0]  nuis_cnt;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ocp_tiered_guard #(
      .MAG_W(MAG_W), .BLANK_LEN(3), .WIN_CYC(2), .CONFIRM_N(3),
      .ACC_W(ACC_W), .PER_W(PER_W), .NC_W(NC_W), .LEAK_SHIFT(0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .edge_stb(edge_stb), .smp_vld(smp_vld),
      .smp_mag(smp_mag), .lim_fast(lim_fast), .lim_win(lim_win),
      .lim_ovl(lim_ovl), .acc_budget(acc_budget), .leak_step(leak_step),
      .per_len(per_len), .trip_clr(trip_clr), .gate_kill(gate_kill),
      .soft_limit(soft_limit), .trip(trip), .trip_path(trip_path),
      .nuis_cnt(nuis_cnt)
   );

   // one entry per switching cycle: blanked mag, quiet mag, soft, trip, path, nuis
   localparam int NV = 17;
   localparam logic [31:0] VEC [NV] = '{
      {12'd100,  12'd100, 1'b0, 1'b0, 2'd0, 4'd0},
      {12'd100,  12'd100, 1'b0, 1'b0, 2'd0, 4'd0},
      {12'd1500, 12'd100, 1'b0, 1'b0, 2'd0, 4'd0},
      {12'd100,  12'd100, 1'b0, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd700, 1'b0, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd100, 1'b1, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd700, 1'b1, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd100, 1'b1, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd100, 1'b1, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd100, 1'b0, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd700, 1'b0, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd100, 1'b1, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd700, 1'b1, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd100, 1'b1, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd700, 1'b1, 1'b0, 2'd0, 4'd1},
      {12'd100,  12'd100, 1'b1, 1'b1, 2'd2, 4'd1},
      {12'd100,  12'd100, 1'b1, 1'b1, 2'd2, 4'd1}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // apply inputs for one clock, return 2 ns after the rising edge
   task automatic step(input bit e, input bit v, input int m);
      edge_stb = e;
      smp_vld  = v;
      smp_mag  = MAG_W'(m);
      @(posedge clk);
      #2;
   endtask

   task automatic run_cyc(input int mb, input int mq);
      step(1'b1, 1'b1, mb);
      step(1'b0, 1'b1, mb);
      step(1'b0, 1'b1, mb);
      step(1'b0, 1'b1, mq);
      step(1'b0, 1'b1, mq);
   endtask

   task automatic clear_step();
      trip_clr = 1'b1;
      step(1'b0, 1'b0, 0);
      trip_clr = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      // R10 reset state
      chk(trip == 1'b0 && gate_kill == 1'b0, "R10 trip/gate after reset", int'(trip), 0);
      chk(soft_limit == 1'b0 && trip_path == 2'd0, "R10 soft/path after reset", int'(trip_path), 0);
      chk(nuis_cnt == '0, "R10 nuis after reset", int'(nuis_cnt), 0);

      // table walk: R2 blanked spike, R3 windows and streak, R7 nuisance
      for (int i = 0; i < NV; i++) begin
         run_cyc(int'(VEC[i][31:20]), int'(VEC[i][19:8]));
         chk(soft_limit == VEC[i][7], $sformatf("R3 soft_limit cycle %0d", i), int'(soft_limit), int'(VEC[i][7]));
         chk(trip == VEC[i][6] && gate_kill == VEC[i][6], $sformatf("R3 trip cycle %0d", i), int'(trip), int'(VEC[i][6]));
         chk(trip_path == VEC[i][5:4], $sformatf("R3 path cycle %0d", i), int'(trip_path), int'(VEC[i][5:4]));
         chk(nuis_cnt == VEC[i][3:0], $sformatf("R7 nuis cycle %0d", i), int'(nuis_cnt), int'(VEC[i][3:0]));
      end

      // R9 clear
      clear_step();
      chk(!trip && !gate_kill && trip_path == 2'd0, "R9 clear drops trip", int'(trip), 0);
      chk(!soft_limit, "R9 clear drops soft_limit", int'(soft_limit), 0);
      chk(nuis_cnt == 4'd1, "R9 clear keeps nuis", int'(nuis_cnt), 1);

      // R2 blanking ignores spikes, R1 fast trip
      step(1'b1, 1'b1, 1500);
      chk(!trip, "R2 edge-cycle spike ignored", int'(trip), 0);
      step(1'b0, 1'b1, 1500);
      step(1'b0, 1'b1, 1500);
      chk(!trip, "R2 blanked spike ignored", int'(trip), 0);
      step(1'b0, 1'b0, 4000);
      chk(!trip, "R1 invalid sample ignored", int'(trip), 0);
      step(1'b0, 1'b1, 1200);
      chk(trip && gate_kill && trip_path == 2'd1, "R1 fast trip path 01", int'(trip_path), 1);
      step(1'b1, 1'b1, 100);
      chk(nuis_cnt == 4'd1, "R7 cycle with real hit not nuisance", int'(nuis_cnt), 1);
      step(1'b0, 1'b1, 100);
      step(1'b0, 1'b1, 100);
      step(1'b0, 1'b0, 0);

      // R6 period clear keeps steady overload under budget
      lim_ovl    = 12'd500;
      acc_budget = 24'd1000;
      leak_step  = 24'd10;
      per_len    = 16'd10;
      clear_step();
      for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 600);
      chk(!trip, "R6 period clear prevents trip", int'(trip), 0);

      // R5 leak then R4 strict budget
      per_len = 16'd1000;
      clear_step();
      for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 600);
      for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 100);
      for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 600);
      chk(!trip, "R5 leak keeps total at budget, R4 equal no trip", int'(trip), 0);
      step(1'b0, 1'b1, 600);
      chk(trip && trip_path == 2'd3, "R4 integral trip path 11", int'(trip_path), 3);
      step(1'b0, 1'b1, 1500);
      chk(trip_path == 2'd3, "R8 first tier kept", int'(trip_path), 3);

      // R7 saturation
      clear_step();
      for (int i = 0; i < 14; i++) run_cyc(1500, 100);
      chk(nuis_cnt == 4'd14, "R7 nuisance count", int'(nuis_cnt), 14);
      for (int i = 0; i < 3; i++) run_cyc(1500, 100);
      chk(nuis_cnt == 4'd15, "R7 nuisance saturates", int'(nuis_cnt), 15);
      chk(!trip, "R7 ringing-only cycles never trip", int'(trip), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule